// File: doc/BRIEF.md
# Warp Issue Scheduler

This block decides, every clock cycle, which of the resident warps of a streaming core send their next instruction to the execute stage. Each warp slot has a residency bit and a pending-issue flag. The flag is raised when the operand-readiness input for that slot is seen high. While the flag stays raised, the slot keeps a saturating wait counter. Among the slots that are both resident and pending, the scheduler grants up to two per cycle. It prefers the slot that has waited longest, and on equal waiting time it prefers the lowest slot number.

Grants are produced combinationally from the registered flags, so a different warp can be granted on every cycle with no bubble between them. A warp granted in one cycle loses its flag at the next clock edge. It can only be picked again after its readiness input goes high in a later cycle. A stall input holds back both grants for the cycle in which it is high. Every thread of a granted warp runs the same instruction, so the block hands out only a warp number.

Top module: `warp_issue_sched`

## Requirements
- R1: A grant is only given to a slot whose residency bit is high in that cycle and whose pending flag is set.
- R2: A resident slot whose flag is clear sets the flag at a clock edge where its readiness bit is high. Its wait count then starts at 0.
- R3: A granted slot clears its flag and wait count at the clock edge closing the grant cycle, even if its readiness bit is high in that cycle; only a readiness bit seen in a later cycle sets the flag again.
- R4: A slot whose residency bit is low at a clock edge clears its flag and wait count.
- R5: The first issue port gets the eligible slot with the largest wait count. The wait count rises by one at each edge the flag is held without being granted, and it saturates at 2^AGE_W-1.
- R6: Among eligible slots with equal wait counts, the lower slot number wins.
- R7: The second issue port gets the best eligible slot other than the one on the first port, using the same ordering. It is empty when fewer than two slots are eligible, and it is never granted without the first port.
- R8: A slot whose flag was set at an edge can be granted in the very next cycle, and consecutive cycles can grant different slots with no idle cycle in between.
- R9: While the stall input is high, neither port is granted and no flag is cleared by issue; wait counts keep advancing.
- R10: A warp number output reads 0 whenever its grant is low.
- R11: During and right after reset all flags are clear and neither port is granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| resident_i | input | NUM_WARPS | Per-slot residency |
| opnd_rdy_i | input | NUM_WARPS | Per-slot operand readiness of the next instruction |
| stall_i | input | 1 | Blocks both grants this cycle |
| issue0_vld_o | output | 1 | First issue port grant |
| issue0_id_o | output | $clog2(NUM_WARPS) | First issue port warp number |
| issue1_vld_o | output | 1 | Second issue port grant |
| issue1_id_o | output | $clog2(NUM_WARPS) | Second issue port warp number |

## Verification
Readiness takes effect at the next edge, so a slot made ready in cycle t can be granted in cycle t+1. Residency and stall act within the same cycle, because both grants are combinational from registered state. The bench therefore drives inputs on the falling edge and compares all four outputs one nanosecond later, against a model that advances its flags and wait counts only after that comparison. Directed phases cover same-cycle re-readiness, ties, saturation, residency loss and stall. A long pseudo-random phase on an 8-slot, 3-bit-age configuration then sweeps mixed patterns.

// File: rtl/wis_pkg.sv
package wis_pkg;
  localparam int unsigned DEF_WARPS = 48;  // 1536 threads / 32 per warp
  localparam int unsigned DEF_AGE_W = 4;
endpackage

// File: rtl/wis_slot_track.sv
module wis_slot_track #(
  parameter int unsigned N     = wis_pkg::DEF_WARPS,
  parameter int unsigned AGE_W = wis_pkg::DEF_AGE_W
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [N-1:0]              resident_i,
  input  logic [N-1:0]              opnd_rdy_i,
  input  logic [N-1:0]              issued_i,
  output logic [N-1:0]              elig_o,
  output logic [N-1:0][AGE_W-1:0]   age_o
);
  localparam logic [AGE_W-1:0] AGE_MAX = {AGE_W{1'b1}};

  logic [N-1:0] pend_q;

  for (genvar g = 0; g < N; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        pend_q[g] <= 1'b0;
        age_o[g]  <= '0;
      end else if (!resident_i[g] || issued_i[g]) begin
        pend_q[g] <= 1'b0;
        age_o[g]  <= '0;
      end else if (!pend_q[g]) begin
        pend_q[g] <= opnd_rdy_i[g];
        age_o[g]  <= '0;
      end else if (age_o[g] != AGE_MAX) begin
        age_o[g]  <= age_o[g] + 1'b1;
      end
    end
  end

  assign elig_o = pend_q & resident_i;

  // R4: loss of residency drops the pending flag
  assert_nonresident_clear_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resident_i == '0) |=> (pend_q == '0));
endmodule

// File: rtl/wis_pick.sv
module wis_pick #(
  parameter int unsigned N     = wis_pkg::DEF_WARPS,
  parameter int unsigned AGE_W = wis_pkg::DEF_AGE_W,
  localparam int unsigned IDW  = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]            cand_i,
  input  logic [N-1:0][AGE_W-1:0] age_i,
  output logic                    found_o,
  output logic [IDW-1:0]          id_o,
  output logic [N-1:0]            onehot_o
);
  logic [AGE_W-1:0] best_age;

  always_comb begin
    found_o  = 1'b0;
    id_o     = '0;
    best_age = '0;
    for (int i = 0; i < N; i++) begin
      // strict compare keeps the lowest index on equal age
      if (cand_i[i] && (!found_o || age_i[i] > best_age)) begin
        found_o  = 1'b1;
        id_o     = IDW'(i);
        best_age = age_i[i];
      end
    end
    onehot_o = found_o ? ({{(N-1){1'b0}}, 1'b1} << id_o) : '0;
  end
endmodule

// File: rtl/warp_issue_sched.sv
module warp_issue_sched #(
  parameter int unsigned NUM_WARPS = wis_pkg::DEF_WARPS,
  parameter int unsigned AGE_W     = wis_pkg::DEF_AGE_W,
  localparam int unsigned IDW      = (NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_WARPS-1:0] resident_i,
  input  logic [NUM_WARPS-1:0] opnd_rdy_i,
  input  logic                 stall_i,
  output logic                 issue0_vld_o,
  output logic [IDW-1:0]       issue0_id_o,
  output logic                 issue1_vld_o,
  output logic [IDW-1:0]       issue1_id_o
);
  logic [NUM_WARPS-1:0]            elig, cand1, oh0, oh1, issued;
  logic [NUM_WARPS-1:0][AGE_W-1:0] age;
  logic                            fnd0, fnd1;
  logic [IDW-1:0]                  id0, id1;

  wis_slot_track #(.N(NUM_WARPS), .AGE_W(AGE_W)) u_track (
    .clk_i, .rst_ni, .resident_i, .opnd_rdy_i,
    .issued_i (issued),
    .elig_o   (elig),
    .age_o    (age)
  );

  wis_pick #(.N(NUM_WARPS), .AGE_W(AGE_W)) u_pick0 (
    .cand_i (elig), .age_i (age), .found_o (fnd0), .id_o (id0), .onehot_o (oh0)
  );

  assign cand1 = elig & ~oh0;

  wis_pick #(.N(NUM_WARPS), .AGE_W(AGE_W)) u_pick1 (
    .cand_i (cand1), .age_i (age), .found_o (fnd1), .id_o (id1), .onehot_o (oh1)
  );

  assign issue0_vld_o = fnd0 & ~stall_i;
  assign issue1_vld_o = fnd1 & ~stall_i;
  assign issue0_id_o  = issue0_vld_o ? id0 : '0;
  assign issue1_id_o  = issue1_vld_o ? id1 : '0;
  assign issued       = stall_i ? '0 : (oh0 | oh1);

  assert_grant_eligible_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue0_vld_o |-> elig[issue0_id_o]);
  assert_reissue_blocked_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue0_vld_o |=> !(issue0_vld_o && issue0_id_o == $past(issue0_id_o))
                  && !(issue1_vld_o && issue1_id_o == $past(issue0_id_o)));
  assert_age_order_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue1_vld_o |-> age[issue1_id_o] <= age[issue0_id_o]);
  assert_tie_low_id_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue1_vld_o && age[issue1_id_o] == age[issue0_id_o]) |-> issue0_id_o < issue1_id_o);
  assert_second_distinct_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue1_vld_o |-> (issue0_vld_o && issue1_id_o != issue0_id_o));
  assert_stall_blocks_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_i |-> !issue0_vld_o && !issue1_vld_o);
  assert_idle_id_zero_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !issue0_vld_o |-> issue0_id_o == '0);
endmodule

// File: tb/warp_issue_sched_test.sv
module warp_issue_sched_test;
  localparam int N = 8;
  localparam int AW = 3;
  localparam int AMAX = 7;

  logic clk = 0, rst_n = 0, stall = 0;
  logic [N-1:0] res = '0, rdy = '0;
  logic g0, g1;
  logic [2:0] w0, w1;
  int errors = 0, checks = 0;
  bit mflag [N];
  int mage [N];
  logic [31:0] seed = 32'h1234_5678;

  always #10 clk = ~clk;

  warp_issue_sched #(.NUM_WARPS(N), .AGE_W(AW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .resident_i(res), .opnd_rdy_i(rdy), .stall_i(stall),
    .issue0_vld_o(g0), .issue0_id_o(w0), .issue1_vld_o(g1), .issue1_id_o(w1)
  );

  task automatic chk(input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", what, act, exp, $time);
    end
  endtask

  // one cycle: drive, compare, advance model
  task automatic step(input string tag, input logic [N-1:0] v, input logic [N-1:0] r, input logic s);
    int b0, b1;
    bit e0, e1;
    @(negedge clk);
    res = v; rdy = r; stall = s;
    #1;
    b0 = 0; b1 = 0; e0 = 0; e1 = 0;
    for (int i = 0; i < N; i++)
      if (v[i] && mflag[i] && (!e0 || mage[i] > mage[b0])) begin e0 = 1; b0 = i; end
    for (int i = 0; i < N; i++)
      if (v[i] && mflag[i] && !(e0 && i == b0) && (!e1 || mage[i] > mage[b1])) begin e1 = 1; b1 = i; end
    if (s) begin e0 = 0; e1 = 0; end
    chk({tag, " R1 R9 port0 grant"}, int'(g0), int'(e0));
    chk({tag, " R5 R6 R10 port0 id"}, int'(w0), e0 ? b0 : 0);
    chk({tag, " R7 R9 port1 grant"}, int'(g1), int'(e1));
    chk({tag, " R7 R10 port1 id"}, int'(w1), e1 ? b1 : 0);
    for (int i = 0; i < N; i++) begin
      if (!v[i] || (e0 && i == b0) || (e1 && i == b1)) begin mflag[i] = 0; mage[i] = 0; end
      else if (!mflag[i]) begin mflag[i] = r[i]; mage[i] = 0; end
      else if (mage[i] < AMAX) mage[i]++;
    end
  endtask

  initial begin
    #(20 * 200000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) begin mflag[i] = 0; mage[i] = 0; end
    res = '1; rdy = '1;
    repeat (3) @(negedge clk);
    chk("R11 reset port0 grant", int'(g0), 0);
    chk("R11 reset port1 grant", int'(g1), 0);
    @(negedge clk); rst_n = 1;
    rdy = '0;
    step("R11", '1, '0, 0);
    // R2 R8: single ready warp granted next cycle
    step("R2", '1, 8'h08, 0);
    step("R8", '1, 8'h10, 0);
    step("R8", '1, 8'h00, 0);
    // R3: readiness held high across the grant cycle
    step("R3", '1, 8'h08, 0);
    step("R3", '1, 8'h08, 0);
    step("R3", '1, 8'h08, 0);
    step("R3", '1, 8'h00, 0);
    step("R3", '1, 8'h00, 0);
    // R6: three equal-age warps
    step("R6", '1, 8'h54, 0);
    step("R6", '1, 8'h00, 0);
    step("R6", '1, 8'h00, 0);
    step("R6", '1, 8'h00, 0);
    // R5 R9: older warp 5 beats younger warp 1 after stall
    step("R5", '1, 8'h20, 1);
    for (int k = 0; k < 3; k++) step("R9", '1, 8'h00, 1);
    step("R5", '1, 8'h02, 1);
    step("R9", '1, 8'h00, 1);
    step("R5", '1, 8'h00, 0);
    // R5: saturation makes both equal, lowest ID wins
    step("R5", '1, 8'h80, 1);
    for (int k = 0; k < 3; k++) step("R5", '1, 8'h00, 1);
    step("R5", '1, 8'h01, 1);
    for (int k = 0; k < 10; k++) step("R5", '1, 8'h00, 1);
    step("R6", '1, 8'h00, 0);
    // R4: residency loss drops the pending flag
    step("R4", '1, 8'h04, 1);
    step("R4", 8'hFB, 8'h00, 1);
    step("R4", '1, 8'h00, 0);
    step("R4", '1, 8'h00, 0);
    // pseudo-random sweep
    for (int k = 0; k < 4000; k++) begin
      logic [N-1:0] v, r;
      logic s;
      seed = seed * 32'd1103515245 + 32'd12345;
      v = (seed[27:25] == 3'd0) ? seed[23:16] : 8'hFF;
      r = seed[15:8] & seed[7:0] & {seed[30:29] != 2'd0 ? 8'hFF : 8'h00};
      s = (seed[31:28] < 4'd5);
      step("R1", v, r, s);
    end
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule